// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block turns a 16-bit CPU address into four chip-select pins. Software programs it through two byte-wide registers on a simple write/read port: a control register and a base-address register for the general-purpose window. On every bus cycle the address and its valid strobe are decoded with no clock delay. The program-memory select covers a window that always ends at the top of memory and whose size comes from a 2-bit code. The general-purpose select covers a power-of-two window placed by the base register, and its size comes from a separate 3-bit input. Two I/O selects take their hits from fixed decode inputs.

When the program and general-purpose windows overlap, a priority bit decides which select fires. Each select can be switched off. A switched-off pin stops acting as a select and drives the general-purpose data supplied for it instead. The I/O selects have a programmable active level. The program and general-purpose selects are always active low. The reset value of the program-select enable follows an operating-mode input that is sampled while reset is held.

All pins here are plain control signals, so there is no valid/ready handshake and no back-pressure. A register write completes in the cycle it is presented.

Top module: `msd_top`

## Requirements
- R1: On a clock edge with `rst_n` low, every control bit clears to 0, except bit 2 (program enable), which takes the value of `mode_expanded`.
- R2: The base register resets to 0x00. It stores write-data bits 7..2 as address bits 15..10, and it always reads back with bits 1..0 equal to 0.
- R3: On a rising edge with `reg_wr` high, the register at `reg_sel` is written: 0 selects control and 1 selects base. `reg_rdata` shows the selected register at all times. Nothing changes without `reg_wr`.
- R4: The program window is set by the size code {bit 1, bit 0} of control. Code 00 covers 0x0000–0xFFFF, 01 covers 0x8000–0xFFFF, 10 covers 0xC000–0xFFFF and 11 covers 0xE000–0xFFFF.
- R5: A `gen_size` of 0 disables the general-purpose select. A value k from 1 to 7 gives a window of 2^(9+k) bytes. Only address bits 15 down to 9+k are compared with the base, and lower base bits are ignored.
- R6: Control bit 3 sets priority. With bit 3 at 0 the program select wins inside an overlap. With bit 3 at 1 the general-purpose select wins. The two never assert together.
- R7: No select asserts while `bus_valid` is low.
- R8: I/O select 1 is asserted when `io1_hit` and `bus_valid` are both high. Its active level comes from control bit 6, and I/O select 2 takes its active level from bit 4. A 0 gives active low and a 1 gives active high.
- R9: A disabled select drives its `*_gpio` input on its pin. I/O select 1 is disabled when control bit 7 is 0. I/O select 2 is disabled when bit 5 is 0. The program select is disabled when bit 2 is 0. The general-purpose select is disabled when `gen_size` is 0.
- R10: The program and general-purpose select pins are active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_expanded | input | 1 | Operating mode sampled in reset (1 = expanded) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register offset: 0 control, 1 base |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| bus_addr | input | 16 | CPU address |
| bus_valid | input | 1 | Address valid strobe |
| gen_size | input | 3 | General window size code |
| io1_hit | input | 1 | Fixed decode for I/O select 1 |
| io2_hit | input | 1 | Fixed decode for I/O select 2 |
| prog_gpio | input | 1 | Port data for the program pin when it is disabled |
| gen_gpio | input | 1 | Port data for the general pin when it is disabled |
| io1_gpio | input | 1 | Port data for the I/O 1 pin when it is disabled |
| io2_gpio | input | 1 | Port data for the I/O 2 pin when it is disabled |
| prog_cs_pin | output | 1 | Program select pin |
| gen_cs_pin | output | 1 | General-purpose select pin |
| io1_cs_pin | output | 1 | I/O select 1 pin |
| io2_cs_pin | output | 1 | I/O select 2 pin |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the base field starting at bit 10, a 2-bit program size code and a 3-bit general size code. These defaults bring every program size and every general window from 1K to 64K within reach. They also cover the case where the general window fully swallows the program window, so that both priority settings can be seen on real overlaps. Random register images and addresses are mixed with directed boundary addresses, so that every enable, polarity and fallback combination reaches the pins.

// File: rtl/msd_pkg.sv
package msd_pkg;

  localparam int REG_W = 8;

  typedef struct packed {
    logic       io1_en;
    logic       io1_pol;
    logic       io2_en;
    logic       io2_pol;
    logic       gen_first;
    logic       prog_en;
    logic [1:0] prog_size;
  } ctrl_t;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_BASE = 1'b1
  } reg_sel_e;

  localparam int PIN_PROG = 0;
  localparam int PIN_GEN  = 1;
  localparam int PIN_IO1  = 2;
  localparam int PIN_IO2  = 3;
  localparam int NUM_PINS = 4;

endpackage

// File: rtl/msd_regs.sv
module msd_regs
  import msd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode_expanded,
  input  logic                         reg_wr,
  input  logic                         reg_sel,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  output ctrl_t                        ctrl,
  output logic [ADDR_W-BASE_LSB-1:0]   base
);

  localparam int BASE_W = ADDR_W - BASE_LSB;
  localparam int PAD_W  = REG_W - BASE_W;

  ctrl_t             ctrl_q;
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q         <= '0;
      ctrl_q.prog_en <= mode_expanded;
      base_q         <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
      else                     base_q <= reg_wdata[REG_W-1 -: BASE_W];
    end
  end

  always_comb begin
    if (reg_sel == SEL_CTRL) reg_rdata = ctrl_q;
    else                     reg_rdata = {base_q, {PAD_W{1'b0}}};
  end

  assign ctrl = ctrl_q;
  assign base = base_q;

  AST_CTRL_RESET_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q.prog_en == $past(mode_expanded)) &&
                     ({ctrl_q[7:3], ctrl_q[1:0]} == '0)); // R1

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CTRL) |=> (reg_rdata == $past(reg_wdata) || reg_sel != SEL_CTRL)); // R3

  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == SEL_BASE) |=> $stable(base_q)); // R3

endmodule

// File: rtl/msd_prog_window.sv
module msd_prog_window #(
  parameter int ADDR_W  = 16,
  parameter int PSIZE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PSIZE_W-1:0] size_code,
  output logic               hit
);

  localparam int NCODES = 1 << PSIZE_W;

  // Window covers addresses whose top size_code bits are all ones.
  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < NCODES - 1; i++) begin
      if (i < int'(size_code)) hit = hit & addr[ADDR_W-1-i];
    end
  end

  AST_PROG_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && size_code != '0) |-> addr[ADDR_W-1]); // R4

endmodule

// File: rtl/msd_gen_window.sv
module msd_gen_window #(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 10,
  parameter int GSIZE_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [ADDR_W-BASE_LSB-1:0]  base,
  input  logic [GSIZE_W-1:0]          gsize,
  output logic                        hit
);

  localparam int BASE_W = ADDR_W - BASE_LSB;

  logic [BASE_W-1:0] need_cmp;
  logic [BASE_W-1:0] differs;

  // Code k compares base bits k-1 and up; lower base bits are ignored.
  for (genvar k = 0; k < BASE_W; k++) begin : g_bit
    assign need_cmp[k] = (int'(gsize) <= k + 1);
    assign differs[k]  = addr[BASE_LSB+k] ^ base[k];
  end

  assign hit = (gsize != '0) && ((differs & need_cmp) == '0);

  AST_GEN_FINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && gsize == GSIZE_W'(1)) |-> (addr[ADDR_W-1:BASE_LSB] == base)); // R5

endmodule

// File: rtl/msd_pin_drive.sv
module msd_pin_drive (
  input  logic en,
  input  logic active_high,
  input  logic sel,
  input  logic gpio,
  output logic pin
);

  assign pin = en ? (sel ~^ active_high) : gpio;

endmodule

// File: rtl/msd_top.sv
module msd_top
  import msd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 10,
  parameter int PSIZE_W  = 2,
  parameter int GSIZE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_expanded,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_valid,
  input  logic [GSIZE_W-1:0] gen_size,
  input  logic               io1_hit,
  input  logic               io2_hit,
  input  logic               prog_gpio,
  input  logic               gen_gpio,
  input  logic               io1_gpio,
  input  logic               io2_gpio,
  output logic               prog_cs_pin,
  output logic               gen_cs_pin,
  output logic               io1_cs_pin,
  output logic               io2_cs_pin
);

  localparam int BASE_W = ADDR_W - BASE_LSB;

  ctrl_t             ctrl;
  logic [BASE_W-1:0] base;
  logic              prog_hit, gen_hit;
  logic              prog_req, gen_req;
  logic              prog_act, gen_act, io1_act, io2_act;

  logic [NUM_PINS-1:0] pin_en, pin_pol, pin_sel, pin_gpio, pin_out;

  msd_regs #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode_expanded(mode_expanded),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctrl(ctrl), .base(base)
  );

  msd_prog_window #(.ADDR_W(ADDR_W), .PSIZE_W(PSIZE_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .size_code(ctrl.prog_size[PSIZE_W-1:0]), .hit(prog_hit)
  );

  msd_gen_window #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .GSIZE_W(GSIZE_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .base(base),
    .gsize(gen_size), .hit(gen_hit)
  );

  // Arbitration among enabled, valid requests only.
  assign prog_req = prog_hit & bus_valid & ctrl.prog_en;
  assign gen_req  = gen_hit  & bus_valid;
  assign prog_act = prog_req & ~(ctrl.gen_first & gen_req);
  assign gen_act  = gen_req  & ~(~ctrl.gen_first & prog_req);
  assign io1_act  = io1_hit & bus_valid & ctrl.io1_en;
  assign io2_act  = io2_hit & bus_valid & ctrl.io2_en;

  assign pin_en   = {ctrl.io2_en, ctrl.io1_en, (gen_size != '0), ctrl.prog_en};
  assign pin_pol  = {ctrl.io2_pol, ctrl.io1_pol, 1'b0, 1'b0};
  assign pin_sel  = {io2_act, io1_act, gen_act, prog_act};
  assign pin_gpio = {io2_gpio, io1_gpio, gen_gpio, prog_gpio};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    msd_pin_drive u_drv (
      .en(pin_en[p]), .active_high(pin_pol[p]), .sel(pin_sel[p]),
      .gpio(pin_gpio[p]), .pin(pin_out[p])
    );
  end

  assign prog_cs_pin = pin_out[PIN_PROG];
  assign gen_cs_pin  = pin_out[PIN_GEN];
  assign io1_cs_pin  = pin_out[PIN_IO1];
  assign io2_cs_pin  = pin_out[PIN_IO2];

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_act && gen_act)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !(prog_act || gen_act || io1_act || io2_act)); // R7

  AST_IO1_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.io1_en && !bus_valid) |-> (io1_cs_pin == !ctrl.io1_pol)); // R8

  AST_PROG_LOW_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.prog_en && prog_act) |-> !prog_cs_pin); // R10

endmodule

// File: tb/msd_top_tb_top.sv
`timescale 1ns/1ps
module msd_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_expanded = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] bus_addr = '0;
  logic        bus_valid = 1'b0;
  logic [2:0]  gen_size = '0;
  logic        io1_hit = 1'b0, io2_hit = 1'b0;
  logic        prog_gpio = 1'b0, gen_gpio = 1'b0, io1_gpio = 1'b0, io2_gpio = 1'b0;
  logic        prog_cs_pin, gen_cs_pin, io1_cs_pin, io2_cs_pin;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] sh_ctrl = '0;
  logic [7:0] sh_base = '0;

  always #2.5 clk = ~clk;

  msd_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_expanded(mode_expanded),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_addr(bus_addr), .bus_valid(bus_valid), .gen_size(gen_size),
    .io1_hit(io1_hit), .io2_hit(io2_hit),
    .prog_gpio(prog_gpio), .gen_gpio(gen_gpio), .io1_gpio(io1_gpio), .io2_gpio(io2_gpio),
    .prog_cs_pin(prog_cs_pin), .gen_cs_pin(gen_cs_pin),
    .io1_cs_pin(io1_cs_pin), .io2_cs_pin(io2_cs_pin)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Expected pins {io2, io1, gen, prog} from the requirements.
  function automatic logic [3:0] ref_pins(input logic [7:0] c, input logic [7:0] b,
                                          input logic [15:0] a, input logic v,
                                          input logic [2:0] gs, input logic h1, input logic h2,
                                          input logic [3:0] gp);
    logic [15:0] lower;
    logic p_req, g_req, p_win, g_win, i1, i2;
    int wb;
    case (c[1:0])
      2'b00: lower = 16'h0000;
      2'b01: lower = 16'h8000;
      2'b10: lower = 16'hC000;
      default: lower = 16'hE000;
    endcase
    p_req = v && c[2] && (a >= lower);
    wb = 9 + int'(gs);
    g_req = v && (gs != 0) &&
            ((32'(a) >> wb) == (32'({b[7:2], 10'b0}) >> wb));
    p_win = p_req && !(c[3] && g_req);
    g_win = g_req && !(!c[3] && p_req);
    i1 = v && h1 && c[7];
    i2 = v && h2 && c[5];
    ref_pins[0] = c[2] ? !p_win : gp[0];
    ref_pins[1] = (gs != 0) ? !g_win : gp[1];
    ref_pins[2] = c[7] ? (c[6] ? i1 : !i1) : gp[2];
    ref_pins[3] = c[5] ? (c[4] ? i2 : !i2) : gp[3];
  endfunction

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (sel) sh_base = {d[7:2], 2'b00};
    else     sh_ctrl = d;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0; mode_expanded = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sh_ctrl = {5'b0, m, 2'b0};
    sh_base = '0;
  endtask

  task automatic drive_check(input string req, input logic [15:0] a, input logic v,
                             input logic h1, input logic h2);
    @(negedge clk);
    bus_addr = a; bus_valid = v; io1_hit = h1; io2_hit = h2;
    #1;
    check(req, {4'b0, io2_cs_pin, io1_cs_pin, gen_cs_pin, prog_cs_pin},
          {4'b0, ref_pins(sh_ctrl, sh_base, a, v, gen_size, h1, h2,
                          {io2_gpio, io1_gpio, gen_gpio, prog_gpio})});
  endtask

  initial begin
    #(5.0 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    logic [15:0] lows [4];
    lows[0] = 16'h0000; lows[1] = 16'h8000; lows[2] = 16'hC000; lows[3] = 16'hE000;
    seed_dummy = $urandom(32'h5EED_0C5);

    // R1: reset image in single-chip mode, then in expanded mode
    do_reset(1'b0);
    reg_sel = 1'b0; #1;
    check("R1 single-chip ctrl", reg_rdata, 8'h00);
    reg_sel = 1'b1; #1;
    check("R2 base reset", reg_rdata, 8'h00);
    do_reset(1'b1);
    reg_sel = 1'b0; #1;
    check("R1 expanded ctrl", reg_rdata, 8'h04);

    // R2/R3: write and read back, unused base bits read 0
    wr_reg(1'b1, 8'hFF);
    reg_sel = 1'b1; #1;
    check("R2 base low bits zero", reg_rdata, 8'hFC);
    wr_reg(1'b0, 8'hA5);
    reg_sel = 1'b0; #1;
    check("R3 ctrl readback", reg_rdata, 8'hA5);
    @(negedge clk); reg_wdata = 8'h3C; reg_sel = 1'b0; reg_wr = 1'b0;
    @(negedge clk); #1;
    check("R3 no write without strobe", reg_rdata, 8'hA5);

    // R4/R10: program window boundaries, general select off
    gen_size = 3'd0;
    for (int s = 0; s < 4; s++) begin
      wr_reg(1'b0, 8'h04 | 8'(s));
      if (s != 0) drive_check("R4 below window", lows[s] - 16'd1, 1'b1, 1'b0, 1'b0);
      drive_check("R4 window start", lows[s], 1'b1, 1'b0, 1'b0);
      drive_check("R10 top address", 16'hFFFF, 1'b1, 1'b0, 1'b0);
    end

    // R7: strobe low, everything enabled and hitting
    wr_reg(1'b0, 8'hFC);
    gen_size = 3'd7;
    drive_check("R7 strobe low", 16'hFFFF, 1'b0, 1'b1, 1'b1);

    // R6: overlap with both priority settings (gen window 64K covers all)
    wr_reg(1'b0, 8'h07);
    drive_check("R6 program priority", 16'hF000, 1'b1, 1'b0, 1'b0);
    wr_reg(1'b0, 8'h0F);
    drive_check("R6 general priority", 16'hF000, 1'b1, 1'b0, 1'b0);

    // R5: 1K window at 0x4000, lower base bits ignored at 8K
    wr_reg(1'b1, 8'h40);
    wr_reg(1'b0, 8'h00);
    gen_size = 3'd1;
    drive_check("R5 1K inside", 16'h43FF, 1'b1, 1'b0, 1'b0);
    drive_check("R5 1K outside", 16'h4400, 1'b1, 1'b0, 1'b0);
    wr_reg(1'b1, 8'h4C);
    gen_size = 3'd4;
    drive_check("R5 8K ignores low base", 16'h4000, 1'b1, 1'b0, 1'b0);

    // R8: both polarities on each I/O select
    for (int pp = 0; pp < 4; pp++) begin
      wr_reg(1'b0, {1'b1, pp[0], 1'b1, pp[1], 4'b0000});
      drive_check("R8 io hit", 16'h1234, 1'b1, 1'b1, 1'b1);
      drive_check("R8 io idle", 16'h1234, 1'b1, 1'b0, 1'b0);
    end

    // R9: all disabled, pins follow port data
    wr_reg(1'b0, 8'h00);
    gen_size = 3'd0;
    prog_gpio = 1'b1; gen_gpio = 1'b0; io1_gpio = 1'b1; io2_gpio = 1'b0;
    drive_check("R9 fallback a", 16'hFFFF, 1'b1, 1'b1, 1'b1);
    prog_gpio = 1'b0; gen_gpio = 1'b1; io1_gpio = 1'b0; io2_gpio = 1'b1;
    drive_check("R9 fallback b", 16'hFFFF, 1'b1, 1'b1, 1'b1);

    // Random mix over R4..R10
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 4) == 0) wr_reg(1'b0, 8'($urandom));
      if (($urandom % 6) == 0) wr_reg(1'b1, 8'($urandom));
      gen_size = 3'($urandom);
      {prog_gpio, gen_gpio, io1_gpio, io2_gpio} = 4'($urandom);
      drive_check("R6 random mix", 16'($urandom), ($urandom % 5) != 0,
                  1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule